// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block generates the horizontal sync, vertical sync and data-enable strobes that pace a pixel output path. Software loads each axis as four lengths (active, front porch, sync, back porch) through a small register port. Each length is the gap between two mode boundaries. For example, the front porch is sync start minus active end, and the back porch is total minus sync end. For an interlaced mode, software programs half of the frame's line count as the vertical active size. One pixel-counter walks each line. A line counter steps once per finished line.

A control word holds four fields: a master enable, a FIFO-clear request, a pixel format selector and a wait-for-line-start option. The block derives a pixel FIFO fill threshold from the selected format and presents it both as an output and as a read-only field. A separate video-enable word starts scanout and chooses between repeating frames and a single frame. Clearing video enable lets the frame in flight complete before the running flag drops, so software can poll for a clean stop. An interrupt status bit latches at the first line of vertical front porch and is cleared by writing one to it.

Top module: `vtg_top`

## Requirements
- R1: After reset every output is low, every register reads zero, and the FIFO threshold shows the 24-bit value. Register map, by address:
  - 0 control: bit0 enable, bit1 FIFO clear, bits3:2 format, bit4 wait-for-line-start, bits15:8 read-only threshold.
  - 1 video: bit0 video enable, bit1 continuous.
  - 2 horizontal A: back porch in 15:0, sync in 31:16.
  - 3 horizontal B: front porch in 15:0, active in 31:16.
  - 4 and 5: the same split for the vertical axis.
  - 6: bit0 interrupt enable.
  - 7: bit0 interrupt status.
  - 8: bit0 running.
- R2: Each line runs active, then front porch, then sync, then back porch. Its period is the sum of the four horizontal fields, and `hsync_o` is high during the sync span.
- R3: The line counter advances on each line wrap through the vertical active, front porch, sync and back porch spans in that order, and `vsync_o` is high during the vertical sync lines.
- R4: `de_o` is high only while running and while both counters are inside their active spans.
- R5: Interrupt status sets on the first pixel of the first vertical front-porch line, and `irq_o` is status AND enable.
- R6: Writing 1 to status bit0 clears it. A set in the same cycle as that write wins.
- R7: Clearing video enable during a frame keeps running high until the last pixel of that frame, and running is low on the cycle that would begin the next frame.
- R8: With continuous set, frames repeat. With it clear, one frame is produced, then running drops and video enable reads back 0.
- R9: FIFO threshold in bytes, over a 64-byte FIFO: format 1 (16-bit) gives 52, format 2 (18-bit) gives 50, and formats 0 and 3 (24-bit) give 46.
- R10: `fifo_clr_o` is high only while both the FIFO-clear and enable bits are set.
- R11: With wait-for-line-start set, sync and data-enable outputs stay low until the first line wrap after start.
- R12: Clearing enable stops the generator on the next cycle, and a later start begins at pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Read data, combinational from read address |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Active video |
| irq_o | output | 1 | Front-porch interrupt |
| running_o | output | 1 | Generator running |
| fifo_clr_o | output | 1 | Pixel FIFO clear request |
| fifo_level_o | output | 8 | Pixel FIFO fill threshold |

## Verification
The two functions that can meet in one cycle are the front-porch status set and the software write-one-to-clear of that status. The bench first clears a pending status mid-frame and expects it low on the next pixel. In the following frame it issues the clear write so that it lands on exactly the clock edge where the line counter enters front porch, and it expects the status and `irq_o` to be high on the following pixel. A second collision is also exercised: a video-enable clear arrives mid-frame, and the bench judges pixel-by-pixel that running and the strobes follow the frame to its last pixel.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,
        A_VCTRL = 4'd1,
        A_H_LO  = 4'd2,
        A_H_HI  = 4'd3,
        A_V_LO  = 4'd4,
        A_V_HI  = 4'd5,
        A_IEN   = 4'd6,
        A_ISTAT = 4'd7,
        A_STAT  = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        FMT_RGB24     = 2'd0,
        FMT_RGB16     = 2'd1,
        FMT_RGB18     = 2'd2,
        FMT_RGB24_ALT = 2'd3
    } pix_fmt_e;

    // Threshold leaves room for the upstream latency in bytes per format.
    function automatic logic [7:0] fifo_level(pix_fmt_e f, int bytes, int lat);
        int r;
        case (f)
            FMT_RGB16: r = bytes - 2 * lat;
            FMT_RGB18: r = bytes - 2 * lat - 2;
            default:   r = bytes - 3 * lat;
        endcase
        return r[7:0];
    endfunction

endpackage

// File: rtl/vtg_axis.sv
module vtg_axis #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          adv_i,
    input  logic [FW-1:0] act_i,
    input  logic [FW-1:0] fp_i,
    input  logic [FW-1:0] sync_i,
    input  logic [FW-1:0] bp_i,
    output logic          wrap_o,
    output logic          in_act_o,
    output logic          in_sync_o,
    output logic          fp_start_o
);
    localparam int TW = FW + 2;
    localparam logic [TW-1:0] ONE = TW'(1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } axis_st_t;

    axis_st_t st_d, st_q;
    logic [TW-1:0] end_act, end_fp, end_sync, total;

    always_comb begin
        end_act  = TW'(act_i);
        end_fp   = end_act + TW'(fp_i);
        end_sync = end_fp + TW'(sync_i);
        total    = end_sync + TW'(bp_i);
    end

    always_comb begin
        wrap_o     = adv_i && ((total == '0) || (st_q.cnt >= total - ONE));
        fp_start_o = adv_i && !wrap_o && (act_i != '0) && (st_q.cnt == end_act - ONE);
        in_act_o   = st_q.cnt < end_act;
        in_sync_o  = (st_q.cnt >= end_fp) && (st_q.cnt < end_sync);
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (adv_i) begin
            st_d.cnt = wrap_o ? '0 : st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && $stable(total) && (total != '0)) |=> (st_q.cnt < $past(total)));

endmodule

// File: rtl/vtg_seq.sv
module vtg_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic video_en_i,
    input  logic cont_i,
    input  logic wait_hs_i,
    input  logic line_end_i,
    input  logic frame_end_i,
    output logic running_o,
    output logic gate_o,
    output logic oneshot_done_o
);
    typedef struct packed {
        logic running;
        logic gate;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        oneshot_done_o = 1'b0;
        if (!enable_i) begin
            st_d = '0;
        end else if (!st_q.running) begin
            if (video_en_i) begin
                st_d.running = 1'b1;
                st_d.gate    = !wait_hs_i;
            end
        end else begin
            if (line_end_i) st_d.gate = 1'b1;
            if (frame_end_i && (!video_en_i || !cont_i)) begin
                st_d           = '0;
                oneshot_done_o = !cont_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running_o = st_q.running;
    assign gate_o    = st_q.gate;

    // R7
    run_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.running) |-> ($past(frame_end_i) || !$past(enable_i)));

    // R12
    stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !st_q.running);

endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int FW         = 16,
    parameter int FIFO_BYTES = 64,
    parameter int LAT_PIX    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [3:0]    wr_addr_i,
    input  logic [31:0]   wr_data_i,
    input  logic [3:0]    rd_addr_i,
    input  logic          running_i,
    input  logic          fp_start_i,
    input  logic          oneshot_done_i,
    output logic [31:0]   rd_data_o,
    output logic          en_o,
    output logic          fclr_o,
    output logic          whs_o,
    output logic          ven_o,
    output logic          cont_o,
    output logic [7:0]    level_o,
    output logic [FW-1:0] hbp_o,
    output logic [FW-1:0] hsy_o,
    output logic [FW-1:0] hfp_o,
    output logic [FW-1:0] hact_o,
    output logic [FW-1:0] vbp_o,
    output logic [FW-1:0] vsy_o,
    output logic [FW-1:0] vfp_o,
    output logic [FW-1:0] vact_o,
    output logic          irq_o
);
    typedef struct packed {
        logic          en;
        logic          fclr;
        logic          whs;
        pix_fmt_e      fmt;
        logic          ven;
        logic          cont;
        logic [FW-1:0] hbp;
        logic [FW-1:0] hsy;
        logic [FW-1:0] hfp;
        logic [FW-1:0] hact;
        logic [FW-1:0] vbp;
        logic [FW-1:0] vsy;
        logic [FW-1:0] vfp;
        logic [FW-1:0] vact;
        logic          ien;
        logic          ist;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_vctrl;

    assign wr_vctrl = wr_en_i && (reg_addr_e'(wr_addr_i) == A_VCTRL);

    always_comb begin
        st_d = st_q;
        if (oneshot_done_i) st_d.ven = 1'b0;
        if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                A_CTRL: begin
                    st_d.en   = wr_data_i[0];
                    st_d.fclr = wr_data_i[1];
                    st_d.fmt  = pix_fmt_e'(wr_data_i[3:2]);
                    st_d.whs  = wr_data_i[4];
                end
                A_VCTRL: begin
                    st_d.ven  = wr_data_i[0];
                    st_d.cont = wr_data_i[1];
                end
                A_H_LO: begin
                    st_d.hbp = wr_data_i[FW-1:0];
                    st_d.hsy = wr_data_i[16 +: FW];
                end
                A_H_HI: begin
                    st_d.hfp  = wr_data_i[FW-1:0];
                    st_d.hact = wr_data_i[16 +: FW];
                end
                A_V_LO: begin
                    st_d.vbp = wr_data_i[FW-1:0];
                    st_d.vsy = wr_data_i[16 +: FW];
                end
                A_V_HI: begin
                    st_d.vfp  = wr_data_i[FW-1:0];
                    st_d.vact = wr_data_i[16 +: FW];
                end
                A_IEN:   st_d.ien = wr_data_i[0];
                A_ISTAT: if (wr_data_i[0]) st_d.ist = 1'b0;
                default: ;
            endcase
        end
        if (fp_start_i) st_d.ist = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = fifo_level(st_q.fmt, FIFO_BYTES, LAT_PIX);

    always_comb begin
        case (reg_addr_e'(rd_addr_i))
            A_CTRL:  rd_data_o = {16'b0, level_o, 3'b0, st_q.whs, st_q.fmt, st_q.fclr, st_q.en};
            A_VCTRL: rd_data_o = {30'b0, st_q.cont, st_q.ven};
            A_H_LO:  rd_data_o = {16'(st_q.hsy), 16'(st_q.hbp)};
            A_H_HI:  rd_data_o = {16'(st_q.hact), 16'(st_q.hfp)};
            A_V_LO:  rd_data_o = {16'(st_q.vsy), 16'(st_q.vbp)};
            A_V_HI:  rd_data_o = {16'(st_q.vact), 16'(st_q.vfp)};
            A_IEN:   rd_data_o = {31'b0, st_q.ien};
            A_ISTAT: rd_data_o = {31'b0, st_q.ist};
            A_STAT:  rd_data_o = {31'b0, running_i};
            default: rd_data_o = '0;
        endcase
    end

    assign en_o   = st_q.en;
    assign fclr_o = st_q.fclr;
    assign whs_o  = st_q.whs;
    assign ven_o  = st_q.ven;
    assign cont_o = st_q.cont;
    assign hbp_o  = st_q.hbp;
    assign hsy_o  = st_q.hsy;
    assign hfp_o  = st_q.hfp;
    assign hact_o = st_q.hact;
    assign vbp_o  = st_q.vbp;
    assign vsy_o  = st_q.vsy;
    assign vfp_o  = st_q.vfp;
    assign vact_o = st_q.vact;
    assign irq_o  = st_q.ist & st_q.ien;

    // R6
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp_start_i |=> st_q.ist);

    // R8
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_done_i && !wr_vctrl) |=> !st_q.ven);

endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
    parameter int FW         = 16,
    parameter int FIFO_BYTES = 64,
    parameter int LAT_PIX    = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [3:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [3:0]  rd_addr_i,
    output logic [31:0] rd_data_o,
    output logic        hsync_o,
    output logic        vsync_o,
    output logic        de_o,
    output logic        irq_o,
    output logic        running_o,
    output logic        fifo_clr_o,
    output logic [7:0]  fifo_level_o
);
    logic          en, fclr, whs, ven, cont;
    logic [FW-1:0] hbp, hsy, hfp, hact, vbp, vsy, vfp, vact;
    logic          running, gate, oneshot_done;
    logic          h_wrap, h_act, h_sync, h_fps;
    logic          v_wrap, v_act, v_sync, v_fps;
    logic          vis;

    vtg_regs #(.FW(FW), .FIFO_BYTES(FIFO_BYTES), .LAT_PIX(LAT_PIX)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en_i        (wr_en_i),
        .wr_addr_i      (wr_addr_i),
        .wr_data_i      (wr_data_i),
        .rd_addr_i      (rd_addr_i),
        .running_i      (running),
        .fp_start_i     (v_fps),
        .oneshot_done_i (oneshot_done),
        .rd_data_o      (rd_data_o),
        .en_o           (en),
        .fclr_o         (fclr),
        .whs_o          (whs),
        .ven_o          (ven),
        .cont_o         (cont),
        .level_o        (fifo_level_o),
        .hbp_o          (hbp),
        .hsy_o          (hsy),
        .hfp_o          (hfp),
        .hact_o         (hact),
        .vbp_o          (vbp),
        .vsy_o          (vsy),
        .vfp_o          (vfp),
        .vact_o         (vact),
        .irq_o          (irq_o)
    );

    vtg_axis #(.FW(FW)) u_hax (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (!running),
        .adv_i      (running),
        .act_i      (hact),
        .fp_i       (hfp),
        .sync_i     (hsy),
        .bp_i       (hbp),
        .wrap_o     (h_wrap),
        .in_act_o   (h_act),
        .in_sync_o  (h_sync),
        .fp_start_o (h_fps)
    );

    vtg_axis #(.FW(FW)) u_vax (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (!running),
        .adv_i      (h_wrap),
        .act_i      (vact),
        .fp_i       (vfp),
        .sync_i     (vsy),
        .bp_i       (vbp),
        .wrap_o     (v_wrap),
        .in_act_o   (v_act),
        .in_sync_o  (v_sync),
        .fp_start_o (v_fps)
    );

    vtg_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable_i       (en),
        .video_en_i     (ven),
        .cont_i         (cont),
        .wait_hs_i      (whs),
        .line_end_i     (h_wrap),
        .frame_end_i    (v_wrap),
        .running_o      (running),
        .gate_o         (gate),
        .oneshot_done_o (oneshot_done)
    );

    logic unused_h_fps;
    assign unused_h_fps = h_fps;

    assign vis        = running & gate;
    assign hsync_o    = vis & h_sync;
    assign vsync_o    = vis & v_sync;
    assign de_o       = vis & h_act & v_act;
    assign running_o  = running;
    assign fifo_clr_o = fclr & en;

endmodule

// File: tb/vtg_top_bench.sv
`timescale 1ns/1ps
module vtg_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic        hsync_o, vsync_o, de_o, irq_o, running_o, fifo_clr_o;
    logic [7:0]  fifo_level_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    vtg_top u_vtg_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .hsync_o      (hsync_o),
        .vsync_o      (vsync_o),
        .de_o         (de_o),
        .irq_o        (irq_o),
        .running_o    (running_o),
        .fifo_clr_o   (fifo_clr_o),
        .fifo_level_o (fifo_level_o)
    );

    // control word, expected fifo_clr, expected threshold
    localparam logic [40:0] FMT_VEC [7] = '{
        {32'h0000_0001, 1'b0, 8'd46},
        {32'h0000_0005, 1'b0, 8'd52},
        {32'h0000_0009, 1'b0, 8'd50},
        {32'h0000_000D, 1'b0, 8'd46},
        {32'h0000_0003, 1'b1, 8'd46},
        {32'h0000_0002, 1'b0, 8'd46},
        {32'h0000_0000, 1'b0, 8'd46}
    };

    task automatic chk1(input string req, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic chk32(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(posedge clk);
        #1;
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr_i = a;
        #1;
        chk32(req, rd_data_o, exp);
    endtask

    // Timing under test: line 4+2+2+1 = 9 pixels, frame 3+1+1+1 = 6 lines.
    function automatic logic [2:0] pix_exp(int p, bit run, bit gate);
        int h = p % 9;
        int v = (p / 9) % 6;
        return {run && gate && (h >= 6) && (h < 8),
                run && gate && (v == 4),
                run && gate && (h < 4) && (v < 3)};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk1("R1 hsync", hsync_o, 1'b0);
        chk1("R1 vsync", vsync_o, 1'b0);
        chk1("R1 de", de_o, 1'b0);
        chk1("R1 irq", irq_o, 1'b0);
        chk1("R1 running", running_o, 1'b0);
        chk1("R1 fifo_clr", fifo_clr_o, 1'b0);
        chk32("R1 level", 32'(fifo_level_o), 32'd46);
        rd_chk("R1 ctrl read", 4'd0, 32'h0000_2E00);
        rd_chk("R1 vctrl read", 4'd1, 32'h0);
        rd_chk("R1 istat read", 4'd7, 32'h0);

        // R9 / R10 vector table
        for (int i = 0; i < 7; i++) begin
            wr(4'd0, FMT_VEC[i][40:9]);
            @(negedge clk);
            chk32("R9 threshold", 32'(fifo_level_o), 32'(FMT_VEC[i][7:0]));
            chk1("R10 fifo clear", fifo_clr_o, FMT_VEC[i][8]);
        end

        wr(4'd2, 32'h0002_0001);
        wr(4'd3, 32'h0004_0002);
        wr(4'd4, 32'h0001_0001);
        wr(4'd5, 32'h0003_0001);
        rd_chk("R1 hb readback", 4'd3, 32'h0004_0002);
        wr(4'd6, 32'h1);
        wr(4'd0, 32'h1);
        wr(4'd1, 32'h3);
        @(posedge clk);
        rd_addr_i = 4'd7;
        // Two continuous frames; W1C at 40, video-enable clear at 60, W1C colliding with set at 80.
        for (int p = 0; p < 112; p++) begin
            bit         run_e;
            bit         irq_e;
            logic [2:0] e;
            @(negedge clk);
            run_e = (p < 108);
            irq_e = ((p >= 27) && (p <= 40)) || (p >= 81);
            e = pix_exp(p, run_e, 1'b1);
            chk1("R7 running", running_o, run_e);
            chk1("R2 hsync", hsync_o, e[2]);
            chk1("R3 vsync", vsync_o, e[1]);
            chk1("R4 de", de_o, e[0]);
            chk1("R6 irq", irq_o, irq_e);
            wr_en_i   = (p == 40) || (p == 60) || (p == 80);
            wr_addr_i = (p == 60) ? 4'd1 : 4'd7;
            wr_data_i = (p == 60) ? 32'h0 : 32'h1;
        end
        rd_chk("R7 running status", 4'd8, 32'h0);

        wr(4'd6, 32'h0);
        @(negedge clk);
        chk1("R5 irq masked", irq_o, 1'b0);
        rd_chk("R5 status held", 4'd7, 32'h1);

        // R8 single frame
        wr(4'd1, 32'h1);
        @(posedge clk);
        for (int p = 0; p < 60; p++) begin
            logic [2:0] e;
            @(negedge clk);
            e = pix_exp(p, p < 54, 1'b1);
            chk1("R8 running", running_o, p < 54);
            chk1("R8 de", de_o, e[0]);
        end
        rd_chk("R8 video enable self-cleared", 4'd1, 32'h0);

        // R11 wait for line start
        wr(4'd0, 32'h11);
        wr(4'd1, 32'h3);
        @(posedge clk);
        for (int p = 0; p < 18; p++) begin
            logic [2:0] e;
            @(negedge clk);
            e = pix_exp(p, 1'b1, p >= 9);
            chk1("R11 hsync", hsync_o, e[2]);
            chk1("R11 de", de_o, e[0]);
        end

        // R12 immediate stop and clean restart
        wr(4'd0, 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk1("R12 running", running_o, 1'b0);
        chk1("R12 hsync", hsync_o, 1'b0);
        chk1("R12 de", de_o, 1'b0);
        wr(4'd0, 32'h1);
        @(posedge clk);
        for (int p = 0; p < 10; p++) begin
            logic [2:0] e;
            @(negedge clk);
            e = pix_exp(p, 1'b1, 1'b1);
            chk1("R12 restart running", running_o, 1'b1);
            chk1("R12 restart hsync", hsync_o, e[2]);
            chk1("R12 restart de", de_o, e[0]);
        end
        wr(4'd1, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule